// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block turns a virtual address into a physical one by searching a small, fully associative table that software fills one entry at a time. Each entry describes a pair of adjacent virtual pages, an even one and an odd one. The two pages share one virtual tag, one address-space identifier and one page size. Each page of the pair has its own frame number, valid flag and dirty flag. A page-size mask in each entry sets the size of both pages, from 4 KB up to 64 MB in steps of four.

A lookup presents a virtual address, the requester's address-space identifier and a read/write flag. One cycle later the block returns one of two results. The first is a physical address with a read-only or read/write grant. The second is a fault code that tells a missing mapping (refill) from a mapping marked not valid (invalid) and from a write to a clean page (modify). A fault response also returns the faulting tag and identifier, so that a handler can refill the table.

The search begins at the entry written most recently and wraps around the table, and the first entry that matches wins. Software therefore gets a fixed, predictable answer even when it leaves overlapping entries in place. Segment decoding and replacement policy belong to the surrounding logic.

Top module: `tlb_pair_lookup`

## Requirements
- R1: Reset clears every entry field to zero, sets the last-written index to 0 and deasserts `rsp_valid`. A read lookup of virtual address 0 with identifier 0 right after reset therefore reports code 3 (invalid-load).
- R2: `rsp_valid` in a cycle equals `req_valid` of the cycle before. The fields of a response describe the request of that earlier cycle.
- R3: A page mask value m (bit j of m covers virtual address bit 13+j) is legal only if m equals 2^c − 1 with c even and c ≤ 14. It then gives the page shift s = 12 + c, and the tag is compared only on virtual address bits above s. An entry that holds an illegal mask never matches.
- R4: Virtual address bit s picks the odd half of the pair when it is 1 and the even half when it is 0.
- R5: An entry matches only when its tag agrees and either its identifier equals the request's identifier or its global bit is set.
- R6: When no entry matches, the code is 1 (refill-load) for a read and 2 (refill-store) for a write.
- R7: When the matching half has its valid bit clear, the code is 3 (invalid-load) for a read and 4 (invalid-store) for a write.
- R8: When the matching half is valid but clean and the request is a write, the code is 5 (modify).
- R9: On success the code is 0. `rsp_rw` equals the dirty bit, and the physical address is ((frame << 12) AND NOT (2^s − 1)) OR (virtual address AND (2^s − 1)).
- R10: The search order is the last-written index, then each following index with wrap-around, and the first match in that order wins.
- R11: A fault response returns virtual address bits [31:13] in `rsp_tag` and the request's identifier in `rsp_asid`, with `rsp_pa` zero and `rsp_rw` low. A success returns zero in `rsp_tag` and `rsp_asid`.
- R12: A write changes the table and the last-written index for lookups in the following cycle. A lookup in the same cycle as a write sees the earlier contents and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_idx | input | IDX_W | Index of the entry being loaded |
| wr_mask | input | 14 | Page-size mask, bit j covers address bit 13+j |
| wr_tag | input | VA_W-13 | Virtual tag, address bits [VA_W-1:13] |
| wr_global | input | 1 | Match regardless of identifier |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_pfn_even | input | PFN_W | Frame number of the even page |
| wr_valid_even | input | 1 | Even page valid |
| wr_dirty_even | input | 1 | Even page writable |
| wr_pfn_odd | input | PFN_W | Frame number of the odd page |
| wr_valid_odd | input | 1 | Odd page valid |
| wr_dirty_odd | input | 1 | Odd page writable |
| req_valid | input | 1 | Lookup request present |
| req_va | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Identifier of the requester |
| req_write | input | 1 | 1 for a store, 0 for a load |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | 0 ok, 1 refill-load, 2 refill-store, 3 invalid-load, 4 invalid-store, 5 modify |
| rsp_pa | output | PFN_W+12 | Physical address on success |
| rsp_rw | output | 1 | Grant is read/write (else read-only) |
| rsp_tag | output | VA_W-13 | Faulting virtual tag |
| rsp_asid | output | ASID_W | Faulting identifier |

## Verification
The assertions take for granted that `req_valid`, `req_write` and the request address are held at known values through every clock edge. They also assume that no lookup is issued during reset, since the one-cycle relations they check start only at the first edge after reset. The stimulus drives every input at the falling edge, keeps `req_valid` low while reset is applied and keeps `wr_idx` inside the table. It deliberately loads an illegal mask, because the design itself must absorb that case and no assertion depends on the masks being legal.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;

   // Page shift range covered by the per-entry mask
   localparam int MIN_SHIFT = 12;
   localparam int MAX_SHIFT = 26;
   localparam int MASK_W    = MAX_SHIFT - MIN_SHIFT;
   localparam int TAG_LSB   = MIN_SHIFT + 1;

   typedef enum logic [2:0] {
      RESP_OK      = 3'd0,
      RESP_MISS_LD = 3'd1,
      RESP_MISS_ST = 3'd2,
      RESP_INV_LD  = 3'd3,
      RESP_INV_ST  = 3'd4,
      RESP_MOD     = 3'd5
   } resp_code_e;

   // A mask is legal when it is a run of ones from bit 0 of even length
   function automatic logic mask_is_legal(input logic [MASK_W-1:0] m);
      logic contiguous;
      contiguous = ((m & (m + MASK_W'(1))) == '0);
      return contiguous && !($countones(m) % 2);
   endfunction

   function automatic logic [4:0] mask_to_shift(input logic [MASK_W-1:0] m);
      return 5'(MIN_SHIFT) + 5'($countones(m));
   endfunction

endpackage

// File: rtl/tlb_pair_entry.sv
module tlb_pair_entry
   import tlb_pair_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PFN_W      = 20,
   parameter int ASID_W     = 8,
   parameter bit PRE_DECODE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_sel,
   input  logic [MASK_W-1:0]     wr_mask,
   input  logic [VA_W-TAG_LSB-1:0] wr_tag,
   input  logic                  wr_global,
   input  logic [ASID_W-1:0]     wr_asid,
   input  logic [PFN_W-1:0]      wr_pfn_even,
   input  logic                  wr_valid_even,
   input  logic                  wr_dirty_even,
   input  logic [PFN_W-1:0]      wr_pfn_odd,
   input  logic                  wr_valid_odd,
   input  logic                  wr_dirty_odd,
   input  logic [VA_W-1:0]       lk_va,
   input  logic [ASID_W-1:0]     lk_asid,
   output logic                  lk_hit,
   output logic [PFN_W-1:0]      lk_pfn,
   output logic                  lk_valid,
   output logic                  lk_dirty,
   output logic [4:0]            lk_shift
);

   localparam int TAG_W = VA_W - TAG_LSB;

   logic [MASK_W-1:0] mask_q;
   logic [TAG_W-1:0]  tag_q;
   logic              global_q;
   logic [ASID_W-1:0] asid_q;
   logic [PFN_W-1:0]  pfn_even_q, pfn_odd_q;
   logic              valid_even_q, valid_odd_q;
   logic              dirty_even_q, dirty_odd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q       <= '0;
         tag_q        <= '0;
         global_q     <= 1'b0;
         asid_q       <= '0;
         pfn_even_q   <= '0;
         pfn_odd_q    <= '0;
         valid_even_q <= 1'b0;
         valid_odd_q  <= 1'b0;
         dirty_even_q <= 1'b0;
         dirty_odd_q  <= 1'b0;
      end else if (wr_sel) begin
         mask_q       <= wr_mask;
         tag_q        <= wr_tag;
         global_q     <= wr_global;
         asid_q       <= wr_asid;
         pfn_even_q   <= wr_pfn_even;
         pfn_odd_q    <= wr_pfn_odd;
         valid_even_q <= wr_valid_even;
         valid_odd_q  <= wr_valid_odd;
         dirty_even_q <= wr_dirty_even;
         dirty_odd_q  <= wr_dirty_odd;
      end
   end

   logic       legal;
   logic [4:0] shift;

   generate
      if (PRE_DECODE) begin : g_pre
         // Page size decoded once, when the entry is loaded
         logic       legal_q;
         logic [4:0] shift_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               legal_q <= 1'b1;
               shift_q <= 5'(MIN_SHIFT);
            end else if (wr_sel) begin
               legal_q <= mask_is_legal(wr_mask);
               shift_q <= mask_to_shift(wr_mask);
            end
         end
         assign legal = legal_q;
         assign shift = shift_q;
      end else begin : g_post
         // Page size decoded on every lookup
         assign legal = mask_is_legal(mask_q);
         assign shift = mask_to_shift(mask_q);
      end
   endgenerate

   logic [TAG_W-1:0] ignore_bits;
   logic             tag_eq;
   logic             asid_ok;
   logic             odd;

   assign ignore_bits = {{(TAG_W-MASK_W){1'b0}}, mask_q};
   assign tag_eq      = (((tag_q ^ lk_va[VA_W-1:TAG_LSB]) & ~ignore_bits) == '0);
   assign asid_ok     = global_q || (asid_q == lk_asid);
   assign odd         = lk_va[shift];

   assign lk_hit   = legal && tag_eq && asid_ok;
   assign lk_pfn   = odd ? pfn_odd_q   : pfn_even_q;
   assign lk_valid = odd ? valid_odd_q : valid_even_q;
   assign lk_dirty = odd ? dirty_odd_q : dirty_even_q;
   assign lk_shift = shift;

endmodule

// File: rtl/tlb_scan_pick.sv
module tlb_scan_pick #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     hits,
   input  logic [IDX_W-1:0] start,
   output logic             any,
   output logic [IDX_W-1:0] sel
);

   // Wrap-around priority: start, start+1, ... , start-1
   always_comb begin
      int j;
      any = 1'b0;
      sel = '0;
      for (int k = 0; k < N; k++) begin
         j = int'(start) + k;
         if (j >= N) j = j - N;
         if (!any && hits[j]) begin
            any = 1'b1;
            sel = IDX_W'(j);
         end
      end
   end

endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
   import tlb_pair_pkg::*;
#(
   parameter int N_ENTRIES  = 8,
   parameter int VA_W       = 32,
   parameter int PFN_W      = 20,
   parameter int ASID_W     = 8,
   parameter bit PRE_DECODE = 1'b1,
   localparam int IDX_W     = $clog2(N_ENTRIES),
   localparam int TAG_W     = VA_W - TAG_LSB,
   localparam int PA_W      = PFN_W + MIN_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [MASK_W-1:0] wr_mask,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_global,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PFN_W-1:0]  wr_pfn_even,
   input  logic              wr_valid_even,
   input  logic              wr_dirty_even,
   input  logic [PFN_W-1:0]  wr_pfn_odd,
   input  logic              wr_valid_odd,
   input  logic              wr_dirty_odd,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic [2:0]        rsp_code,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_rw,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [ASID_W-1:0] rsp_asid
);

   // Elaboration-time parameter checks
   generate
      if (N_ENTRIES < 2) begin : g_chk_n
         $error("N_ENTRIES must be at least 2");
      end
      if (VA_W <= MAX_SHIFT || VA_W > 64) begin : g_chk_va
         $error("VA_W must cover the largest page shift and stay within 64");
      end
      if (PA_W <= MAX_SHIFT) begin : g_chk_pa
         $error("PFN_W too small for the largest page");
      end
   endgenerate

   // Most recently written index
   logic [IDX_W-1:0] last_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     last_q <= '0;
      else if (wr_en) last_q <= wr_idx;
   end

   logic [N_ENTRIES-1:0] e_hit;
   logic [PFN_W-1:0]     e_pfn   [N_ENTRIES];
   logic                 e_valid [N_ENTRIES];
   logic                 e_dirty [N_ENTRIES];
   logic [4:0]           e_shift [N_ENTRIES];

   generate
      for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
         logic sel_wr;
         assign sel_wr = wr_en && (wr_idx == IDX_W'(i));
         tlb_pair_entry #(
            .VA_W       (VA_W),
            .PFN_W      (PFN_W),
            .ASID_W     (ASID_W),
            .PRE_DECODE (PRE_DECODE)
         ) u_entry (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_sel        (sel_wr),
            .wr_mask       (wr_mask),
            .wr_tag        (wr_tag),
            .wr_global     (wr_global),
            .wr_asid       (wr_asid),
            .wr_pfn_even   (wr_pfn_even),
            .wr_valid_even (wr_valid_even),
            .wr_dirty_even (wr_dirty_even),
            .wr_pfn_odd    (wr_pfn_odd),
            .wr_valid_odd  (wr_valid_odd),
            .wr_dirty_odd  (wr_dirty_odd),
            .lk_va         (req_va),
            .lk_asid       (req_asid),
            .lk_hit        (e_hit[i]),
            .lk_pfn        (e_pfn[i]),
            .lk_valid      (e_valid[i]),
            .lk_dirty      (e_dirty[i]),
            .lk_shift      (e_shift[i])
         );
      end
   endgenerate

   logic             any_hit;
   logic [IDX_W-1:0] win;

   tlb_scan_pick #(
      .N     (N_ENTRIES),
      .IDX_W (IDX_W)
   ) u_pick (
      .hits  (e_hit),
      .start (last_q),
      .any   (any_hit),
      .sel   (win)
   );

   logic [PFN_W-1:0] w_pfn;
   logic             w_valid, w_dirty;
   logic [4:0]       w_shift;
   logic [PA_W-1:0]  off_mask;
   logic [PA_W-1:0]  va_ext;

   assign w_pfn    = e_pfn[win];
   assign w_valid  = e_valid[win];
   assign w_dirty  = e_dirty[win];
   assign w_shift  = e_shift[win];
   assign off_mask = (PA_W'(1) << w_shift) - PA_W'(1);
   assign va_ext   = PA_W'(req_va);

   resp_code_e       nx_code;
   logic [PA_W-1:0]  nx_pa;
   logic             nx_rw;
   logic [TAG_W-1:0] nx_tag;
   logic [ASID_W-1:0] nx_asid;

   always_comb begin
      nx_code = RESP_OK;
      nx_pa   = '0;
      nx_rw   = 1'b0;
      nx_tag  = req_va[VA_W-1:TAG_LSB];
      nx_asid = req_asid;
      if (!any_hit) begin
         nx_code = req_write ? RESP_MISS_ST : RESP_MISS_LD;
      end else if (!w_valid) begin
         nx_code = req_write ? RESP_INV_ST : RESP_INV_LD;
      end else if (req_write && !w_dirty) begin
         nx_code = RESP_MOD;
      end else begin
         nx_pa   = ({w_pfn, {MIN_SHIFT{1'b0}}} & ~off_mask) | (va_ext & off_mask);
         nx_rw   = w_dirty;
         nx_tag  = '0;
         nx_asid = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_code  <= 3'd0;
         rsp_pa    <= '0;
         rsp_rw    <= 1'b0;
         rsp_tag   <= '0;
         rsp_asid  <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_code <= nx_code;
            rsp_pa   <= nx_pa;
            rsp_rw   <= nx_rw;
            rsp_tag  <= nx_tag;
            rsp_asid <= nx_asid;
         end
      end
   end

endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
   parameter int VA_W   = 32,
   parameter int PA_W   = 32,
   parameter int ASID_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [VA_W-1:0]   req_va,
   input logic [ASID_W-1:0] req_asid,
   input logic              req_write,
   input logic              rsp_valid,
   input logic [2:0]        rsp_code,
   input logic [PA_W-1:0]   rsp_pa,
   input logic              rsp_rw,
   input logic [VA_W-14:0]  rsp_tag,
   input logic [ASID_W-1:0] rsp_asid
);

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);  // R2
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);  // R2
   AST_LOAD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> (rsp_code != 3'd2 && rsp_code != 3'd4 && rsp_code != 3'd5));  // R8
   AST_STORE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_code != 3'd1 && rsp_code != 3'd3));  // R6
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_code <= 3'd5);  // R7
   AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_code != 3'd0 || rsp_pa[11:0] == $past(req_va[11:0])));  // R9
   AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 3'd0) |-> (rsp_pa == '0 && !rsp_rw));  // R11
   AST_FAULT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_code == 3'd0 || rsp_tag == $past(req_va[VA_W-1:13])));  // R11
   AST_FAULT_ASID: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_code == 3'd0 || rsp_asid == $past(req_asid)));  // R11

endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(
   .VA_W   (VA_W),
   .PA_W   (PA_W),
   .ASID_W (ASID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_va    (req_va),
   .req_asid  (req_asid),
   .req_write (req_write),
   .rsp_valid (rsp_valid),
   .rsp_code  (rsp_code),
   .rsp_pa    (rsp_pa),
   .rsp_rw    (rsp_rw),
   .rsp_tag   (rsp_tag),
   .rsp_asid  (rsp_asid)
);

// File: tb/tlb_pair_lookup_tb_top.sv
module tlb_pair_lookup_tb_top;

   localparam int N  = 8;
   localparam int VW = 32;
   localparam int FW = 20;
   localparam int AW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          wr_en = 0;
   logic [2:0]    wr_idx = 0;
   logic [13:0]   wr_mask = 0;
   logic [18:0]   wr_tag = 0;
   logic          wr_global = 0;
   logic [AW-1:0] wr_asid = 0;
   logic [FW-1:0] wr_pfn_even = 0, wr_pfn_odd = 0;
   logic          wr_valid_even = 0, wr_dirty_even = 0, wr_valid_odd = 0, wr_dirty_odd = 0;
   logic          req_valid = 0, req_write = 0;
   logic [VW-1:0] req_va = 0;
   logic [AW-1:0] req_asid = 0;
   logic          rsp_valid, rsp_rw;
   logic [2:0]    rsp_code;
   logic [31:0]   rsp_pa;
   logic [18:0]   rsp_tag;
   logic [AW-1:0] rsp_asid;

   tlb_pair_lookup dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
      .wr_tag(wr_tag), .wr_global(wr_global), .wr_asid(wr_asid),
      .wr_pfn_even(wr_pfn_even), .wr_valid_even(wr_valid_even), .wr_dirty_even(wr_dirty_even),
      .wr_pfn_odd(wr_pfn_odd), .wr_valid_odd(wr_valid_odd), .wr_dirty_odd(wr_dirty_odd),
      .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid), .req_write(req_write),
      .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_rw(rsp_rw),
      .rsp_tag(rsp_tag), .rsp_asid(rsp_asid)
   );

   // Reference table
   int      m_mask [N];
   longint  m_tag  [N];
   bit      m_g    [N];
   int      m_asid [N];
   longint  m_pfn  [N][2];
   bit      m_v    [N][2];
   bit      m_d    [N][2];
   int      m_last;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   bit  wr_pend = 0;

   function automatic void model(input longint va, input int asid, input bit wr,
                                 output int code, output longint pa, output bit rw);
      code = wr ? 2 : 1; pa = 0; rw = 0;
      for (int k = 0; k < N; k++) begin
         int j, c, sh, h;
         j = (m_last + k) % N;
         c = $countones(m_mask[j]);
         if (m_mask[j] != ((1 << c) - 1) || (c % 2) != 0) continue;
         sh = 12 + c;
         if ((va >> (sh + 1)) != ((m_tag[j] << 13) >> (sh + 1))) continue;
         if (!m_g[j] && m_asid[j] != asid) continue;
         h = int'((va >> sh) & 1);
         if (!m_v[j][h])              begin code = wr ? 4 : 3; return; end
         if (wr && !m_d[j][h])        begin code = 5; return; end
         code = 0;
         rw   = m_d[j][h];
         pa   = ((m_pfn[j][h] << 12) & ~((64'd1 << sh) - 1)) | (va & ((64'd1 << sh) - 1));
         return;
      end
   endfunction

   task automatic load(input int idx, input int mask, input longint va_base, input bit g,
                       input int asid, input int pe, input bit ve, input bit de,
                       input int po, input bit vo, input bit d_o);
      wr_pend = 1; wr_idx = 3'(idx); wr_mask = 14'(mask); wr_tag = 19'(va_base >> 13);
      wr_global = g; wr_asid = AW'(asid);
      wr_pfn_even = FW'(pe); wr_valid_even = ve; wr_dirty_even = de;
      wr_pfn_odd  = FW'(po); wr_valid_odd  = vo; wr_dirty_odd  = d_o;
   endtask

   task automatic step(input bit rv, input longint va, input int asid, input bit wr,
                       input string tag);
      int e_code; longint e_pa; bit e_rw;
      logic [18:0] e_tag; int e_asid;
      req_valid = rv; req_va = VW'(va); req_asid = AW'(asid); req_write = wr;
      wr_en = wr_pend;
      model(va, asid, wr, e_code, e_pa, e_rw);
      e_tag  = (e_code == 0) ? 19'd0 : 19'(va >> 13);
      e_asid = (e_code == 0) ? 0 : asid;
      if (wr_pend) begin
         int i = int'(wr_idx);
         m_mask[i] = int'(wr_mask); m_tag[i] = longint'(wr_tag); m_g[i] = wr_global;
         m_asid[i] = int'(wr_asid);
         m_pfn[i][0] = longint'(wr_pfn_even); m_v[i][0] = wr_valid_even; m_d[i][0] = wr_dirty_even;
         m_pfn[i][1] = longint'(wr_pfn_odd);  m_v[i][1] = wr_valid_odd;  m_d[i][1] = wr_dirty_odd;
         m_last = i;
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; wr_pend = 0; req_valid = 0;
      checks++;
      if (!rv) begin
         if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: rsp_valid actual %b expected 0", tag, rsp_valid);
         end
      end else if (rsp_valid !== 1'b1 || rsp_code !== 3'(e_code) || rsp_pa !== 32'(e_pa) ||
                   rsp_rw !== e_rw || rsp_tag !== e_tag || rsp_asid !== AW'(e_asid)) begin
         errors++;
         $display("FAIL %s: va %h actual v%b code %0d pa %h rw %b tag %h asid %h expected v1 code %0d pa %h rw %b tag %h asid %h",
                  tag, va[31:0], rsp_valid, rsp_code, rsp_pa, rsp_rw, rsp_tag, rsp_asid,
                  e_code, e_pa[31:0], e_rw, e_tag, e_asid[7:0]);
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_mask[i] = 0; m_tag[i] = 0; m_g[i] = 0; m_asid[i] = 0;
         for (int h = 0; h < 2; h++) begin m_pfn[i][h] = 0; m_v[i][h] = 0; m_d[i][h] = 0; end
      end
      m_last = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      checks++;
      if (rsp_valid !== 1'b0) begin
         errors++; $display("FAIL R1: rsp_valid actual %b expected 0", rsp_valid);
      end
      step(0, 0, 0, 0, "R1");
      step(1, 32'h0000_0000, 0, 0, "R1");
      // R9/R8/R5/R6: 4 KB pair
      load(2, 0, 32'h0040_0000, 0, 5, 'h12345, 1, 1, 'h54321, 1, 0);
      step(0, 0, 0, 0, "R12");
      step(1, 32'h0040_0123, 5, 0, "R9");
      step(1, 32'h0040_0123, 5, 1, "R9");
      step(1, 32'h0040_1abc, 5, 0, "R4");
      step(1, 32'h0040_1abc, 5, 1, "R8");
      step(1, 32'h0040_1abc, 6, 0, "R5");
      step(1, 32'h0040_1abc, 6, 1, "R6");
      step(1, 32'h0040_2000, 5, 0, "R6");
      // R5/R7: global entry with invalid even half
      load(3, 0, 32'h0800_0000, 1, 9, 'h00777, 0, 1, 'h00888, 1, 1);
      step(0, 0, 0, 0, "R12");
      step(1, 32'h0800_0010, 77, 0, "R7");
      step(1, 32'h0800_0010, 3, 1, "R7");
      step(1, 32'h0800_1010, 200, 1, "R5");
      // R3/R4: 16 KB and 64 MB pages
      load(4, 'h3, 32'h1000_0000, 0, 1, 'h00ab0, 1, 1, 'h00ab7, 1, 1);
      step(0, 0, 0, 0, "R3");
      step(1, 32'h1000_5abc, 1, 0, "R3");
      step(1, 32'h1000_2abc, 1, 1, "R4");
      step(1, 32'h1000_8abc, 1, 0, "R3");
      load(5, 'h3fff, 32'h4000_0000, 0, 1, 'hfffff, 1, 0, 'h12000, 1, 1);
      step(0, 0, 0, 0, "R3");
      step(1, 32'h43ff_f123, 1, 0, "R3");
      step(1, 32'h47ab_cdef, 1, 1, "R4");
      step(1, 32'h4800_0000, 1, 0, "R3");
      // R3: illegal mask never matches
      load(6, 'h5, 32'h2000_0000, 1, 1, 'h00111, 1, 1, 'h00222, 1, 1);
      step(0, 0, 0, 0, "R3");
      step(1, 32'h2000_0100, 1, 0, "R3");
      // R10: scan order from last-written index
      load(0, 0, 32'h3000_0000, 0, 1, 'h00100, 1, 1, 'h00101, 1, 1);
      step(0, 0, 0, 0, "R10");
      load(1, 0, 32'h3000_0000, 0, 1, 'h00200, 1, 1, 'h00201, 1, 1);
      step(0, 0, 0, 0, "R10");
      step(1, 32'h3000_0444, 1, 0, "R10");
      load(7, 0, 32'h7000_0000, 0, 2, 'h00300, 1, 1, 'h00301, 1, 1);
      step(0, 0, 0, 0, "R10");
      step(1, 32'h3000_0444, 1, 1, "R10");
      // R12: write and lookup in the same cycle
      load(2, 0, 32'h0040_0000, 0, 8, 'h0abcd, 1, 1, 'h0dcba, 1, 1);
      step(1, 32'h0040_0123, 5, 0, "R12");
      step(1, 32'h0040_0123, 5, 0, "R12");
      step(1, 32'h0040_0123, 8, 0, "R12");
      // R2/R11: back-to-back and mixed traffic
      for (int n = 0; n < 300; n++) begin
         longint va; int a; int pick;
         pick = $urandom_range(0, 6);
         case (pick)
            0: va = 32'h0040_0000 + $urandom_range(0, 'h1fff);
            1: va = 32'h0800_0000 + $urandom_range(0, 'h1fff);
            2: va = 32'h1000_0000 + $urandom_range(0, 'hffff);
            3: va = 32'h4000_0000 + $urandom_range(0, 'hfff_ffff);
            4: va = 32'h3000_0000 + $urandom_range(0, 'h1fff);
            5: va = 32'h7000_0000 + $urandom_range(0, 'h3fff);
            default: va = longint'($urandom);
         endcase
         a = (pick == 6) ? 0 : int'($urandom_range(0, 2)) * 4 + 1;
         step($urandom_range(0, 3) != 0, va, a, $urandom_range(0, 1) == 1, "R11");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual no completion expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule